// File: doc/BRIEF.md
# TDM Bit-Window Tap Receiver

This block listens on a time-division multiplexed serial line and taps it at bit granularity rather than in whole slots. A one-cycle bit strobe marks each bit period on the core clock. On a strobe, the block samples an active-low frame marker and a data bit. A position counter restarts at every frame marker and otherwise advances by one per bit, wrapping after a full frame of `FRAME_BITS` bits.

Two windows are set by four bit-count bounds. Bits whose position lies inside the capture window are shifted into a holding register. The byte-wide display outputs take the new value in a single step when the last bit of that window arrives, so a half-shifted value never appears. While the position lies inside the drive window, the block enables its line driver and sends a parallel input byte, most significant bit first. It takes that byte at the start of the window. The intended setup is a 40-bit capture window from bit 32 to bit 72, covering five displays, and an 8-bit drive window from bit 96 to bit 104, both in a 1024-bit frame.

Top module: `tdm_tap_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it, `disp_out` is all zeros and `line_oe` and `line_out` are low.
- R2: Sampled bits take positions 0 to FRAME_BITS-1. A strobe with `fsync_n` low is position 0. Each other strobe is the previous position plus one, and position FRAME_BITS-1 is followed by position 0 when no frame marker arrives.
- R3: Until the first strobe with `fsync_n` low after reset, no bit is captured and `line_oe` stays low.
- R4: Bits at positions `cap_lo` to `cap_hi`-1 are shifted into the holding register in arrival order. The register is cleared when position `cap_lo` is sampled. The last bit lands in `disp_out` bit 0, earlier bits sit at higher bit positions, and bit positions above the window width are zero. Display byte k is `disp_out[8k+7:8k]`.
- R5: `disp_out` changes only on the clock edge that samples position `cap_hi`-1. A frame marker that arrives before that position leaves the display unchanged.
- R6: Bits sampled outside the capture window have no effect on `disp_out`.
- R7: In the drive window, `line_out` carries `drv_byte`, most significant bit first. `drv_byte` is taken on the strobe that samples position `drv_lo`-1, so bit 7 is on the line during position `drv_lo`. Positions beyond the eighth carry zero.
- R8: `line_oe` is high exactly during positions `drv_lo` to `drv_hi`-1. `line_out` is low whenever `line_oe` is low. Both hold their values between strobes.
- R9: A frame marker in the middle of a frame restarts the count at 0. Capture then starts over at `cap_lo`, and bits from the cut-short frame are discarded.
- R10: Changes to `drv_byte` after it has been taken do not alter the bits driven in the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe per bit period of the line |
| fsync_n | input | 1 | Active-low frame marker, sampled on `bit_tick` |
| line_in | input | 1 | Serial data, sampled on `bit_tick` |
| cap_lo | input | CNT_W | First bit position of the capture window |
| cap_hi | input | CNT_W | Bit position just past the capture window |
| drv_lo | input | CNT_W | First bit position of the drive window |
| drv_hi | input | CNT_W | Bit position just past the drive window |
| drv_byte | input | 8 | Parallel byte sent in the drive window |
| disp_out | output | NUM_DISP*8 | Byte-wide display outputs |
| line_out | output | 1 | Serial data driven onto the line |
| line_oe | output | 1 | Enable for the line driver |

## Verification
The hardest case to reach is position counting across frame boundaries. This covers the wrap after a full frame with no marker, and a marker that lands inside the capture window and cuts a capture short. The stimulus runs one frame of exactly `FRAME_BITS` bits with no closing marker and keeps clocking until the capture window comes round again. It then places a marker eighteen bits into the capture window and starts a fresh frame. The bench also switches to a narrow window layout, with an 8-bit capture and a 4-bit drive window, so that the zero fill and the truncated byte are both seen at the ports.

// File: rtl/tdm_tap_pkg.sv
package tdm_tap_pkg;

    localparam int unsigned BYTE_W = 8;

    // one sampled bit of the line, as seen on the core clock
    typedef struct packed {
        logic tick;   // strobe present this cycle
        logic live;   // strobe and the counter is locked to a frame
        logic sync;   // frame marker on this strobe
        logic data;   // sampled line value
    } bit_evt_t;

    // what the line driver does on a cycle
    typedef enum logic [1:0] {
        DRV_HOLD  = 2'd0,
        DRV_IDLE  = 2'd1,
        DRV_LOAD  = 2'd2,
        DRV_SHIFT = 2'd3
    } drv_op_e;

    function automatic logic in_window(int unsigned pos, int unsigned lo, int unsigned hi);
        return (pos >= lo) && (pos < hi);
    endfunction

    function automatic int unsigned step_pos(int unsigned pos, int unsigned frame_len);
        return (pos + 1 >= frame_len) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/tdm_bitpos.sv
module tdm_bitpos
    import tdm_tap_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 1024,
    parameter int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             fsync_n,
    input  logic             line_in,
    output bit_evt_t         evt,
    output logic [CNT_W-1:0] cur_pos,
    output logic [CNT_W-1:0] nxt_pos
);

    logic [CNT_W-1:0] pos_q;
    logic             locked_q;
    logic             sync;

    always_comb begin
        sync     = bit_tick && !fsync_n;
        cur_pos  = sync ? '0 : CNT_W'(step_pos(32'(pos_q), FRAME_BITS));
        nxt_pos  = CNT_W'(step_pos(32'(cur_pos), FRAME_BITS));
        evt.tick = bit_tick;
        evt.live = bit_tick && (locked_q || sync);
        evt.sync = sync;
        evt.data = line_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            locked_q <= 1'b0;
        end else if (bit_tick) begin
            pos_q <= cur_pos;
            if (sync) begin
                locked_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_capture.sv
module tdm_capture
    import tdm_tap_pkg::*;
#(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned DISP_BITS = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bit_evt_t             evt,
    input  logic [CNT_W-1:0]     cur_pos,
    input  logic [CNT_W-1:0]     lo,
    input  logic [CNT_W-1:0]     hi,
    output logic [DISP_BITS-1:0] disp
);

    logic [DISP_BITS-1:0] shift_q;
    logic [DISP_BITS-1:0] shift_d;
    logic                 hit;
    logic                 first;
    logic                 last;

    always_comb begin
        hit     = evt.live && in_window(32'(cur_pos), 32'(lo), 32'(hi));
        first   = (cur_pos == lo);
        last    = (32'(cur_pos) + 1 == 32'(hi));
        shift_d = first ? {{(DISP_BITS-1){1'b0}}, evt.data}
                        : {shift_q[DISP_BITS-2:0], evt.data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            disp    <= '0;
        end else if (hit) begin
            shift_q <= shift_d;
            if (last) begin
                disp <= shift_d;
            end
        end
    end

endmodule

// File: rtl/tdm_drive.sv
module tdm_drive
    import tdm_tap_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt,
    input  logic [CNT_W-1:0]  nxt_pos,
    input  logic [CNT_W-1:0]  lo,
    input  logic [CNT_W-1:0]  hi,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              oe,
    output logic              dout
);

    logic [BYTE_W-1:0] sh_q;
    drv_op_e           op;

    always_comb begin
        if (!evt.tick) begin
            op = DRV_HOLD;
        end else if (evt.live && in_window(32'(nxt_pos), 32'(lo), 32'(hi))) begin
            op = (nxt_pos == lo) ? DRV_LOAD : DRV_SHIFT;
        end else begin
            op = DRV_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            oe   <= 1'b0;
            dout <= 1'b0;
        end else begin
            case (op)
                DRV_LOAD: begin
                    sh_q <= {byte_in[BYTE_W-2:0], 1'b0};
                    dout <= byte_in[BYTE_W-1];
                    oe   <= 1'b1;
                end
                DRV_SHIFT: begin
                    sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                    dout <= sh_q[BYTE_W-1];
                    oe   <= 1'b1;
                end
                DRV_IDLE: begin
                    dout <= 1'b0;
                    oe   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tdm_tap_rx.sv
module tdm_tap_rx
    import tdm_tap_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 1024,
    parameter int unsigned NUM_DISP   = 5,
    localparam int unsigned CNT_W     = $clog2(FRAME_BITS),
    localparam int unsigned DISP_BITS = NUM_DISP * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_tick,
    input  logic                 fsync_n,
    input  logic                 line_in,
    input  logic [CNT_W-1:0]     cap_lo,
    input  logic [CNT_W-1:0]     cap_hi,
    input  logic [CNT_W-1:0]     drv_lo,
    input  logic [CNT_W-1:0]     drv_hi,
    input  logic [BYTE_W-1:0]    drv_byte,
    output logic [DISP_BITS-1:0] disp_out,
    output logic                 line_out,
    output logic                 line_oe
);

    bit_evt_t         evt;
    logic [CNT_W-1:0] cur_pos;
    logic [CNT_W-1:0] nxt_pos;

    tdm_bitpos #(
        .FRAME_BITS(FRAME_BITS),
        .CNT_W     (CNT_W)
    ) u_pos (
        .clk     (clk),
        .rst     (rst),
        .bit_tick(bit_tick),
        .fsync_n (fsync_n),
        .line_in (line_in),
        .evt     (evt),
        .cur_pos (cur_pos),
        .nxt_pos (nxt_pos)
    );

    tdm_capture #(
        .CNT_W    (CNT_W),
        .DISP_BITS(DISP_BITS)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .cur_pos(cur_pos),
        .lo     (cap_lo),
        .hi     (cap_hi),
        .disp   (disp_out)
    );

    tdm_drive #(
        .CNT_W(CNT_W)
    ) u_drv (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .nxt_pos(nxt_pos),
        .lo     (drv_lo),
        .hi     (drv_hi),
        .byte_in(drv_byte),
        .oe     (line_oe),
        .dout   (line_out)
    );

endmodule

// File: rtl/tdm_tap_chk.sv
module tdm_tap_chk #(
    parameter int unsigned DISP_BITS = 40
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bit_tick,
    input logic                 fsync_n,
    input logic [DISP_BITS-1:0] disp_out,
    input logic                 line_out,
    input logic                 line_oe
);

    logic seen_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sync <= 1'b0;
        end else if (bit_tick && !fsync_n) begin
            seen_sync <= 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (disp_out == '0 && !line_oe && !line_out));

    p_no_drive_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> seen_sync);

    p_disp_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_out != $past(disp_out)) |-> $past(bit_tick));

    p_disp_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(disp_out));

    p_quiet_line_r8: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> !line_out);

    p_oe_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> ($stable(line_oe) && $stable(line_out)));

endmodule

bind tdm_tap_rx tdm_tap_chk #(.DISP_BITS(DISP_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_tick(bit_tick),
    .fsync_n (fsync_n),
    .disp_out(disp_out),
    .line_out(line_out),
    .line_oe (line_oe)
);

// File: tb/sim_tdm_tap_rx.sv
`timescale 1ns/1ps
module sim_tdm_tap_rx;

    localparam int FB = 1024;
    localparam int DB = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        fsync_n = 1'b1;
    logic        line_in = 1'b0;
    logic [9:0]  cap_lo = 10'd32, cap_hi = 10'd72, drv_lo = 10'd96, drv_hi = 10'd104;
    logic [7:0]  drv_byte = 8'h00;
    logic [DB-1:0] disp_out;
    logic        line_out, line_oe;

    always #2.5 clk = ~clk;

    tdm_tap_rx u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .fsync_n(fsync_n), .line_in(line_in),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .drv_lo(drv_lo), .drv_hi(drv_hi),
        .drv_byte(drv_byte), .disp_out(disp_out), .line_out(line_out), .line_oe(line_oe)
    );

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    bit any_oe = 1'b0;
    bit obs_oe [FB];
    bit obs_tx [FB];
    int chg_at = -1;
    logic [7:0] chg_val = 8'h00;

    // behavioural reference model
    int         m_pos = 0;
    bit         m_locked = 1'b0;
    bit         m_capq[$];
    bit         m_txq[$];
    logic [DB-1:0] m_disp = '0;
    bit         m_oe = 1'b0;
    bit         m_tx = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_locked = 0; m_disp = '0; m_oe = 0; m_tx = 0;
            m_capq.delete(); m_txq.delete();
        end else if (bit_tick) begin
            int nxt;
            if (!fsync_n) begin m_pos = 0; m_locked = 1; end
            else m_pos = (m_pos + 1) % FB;
            if (m_locked) begin
                if (m_pos == int'(cap_lo)) m_capq.delete();
                if (m_pos >= int'(cap_lo) && m_pos < int'(cap_hi)) m_capq.push_back(line_in);
                if (m_pos == int'(cap_hi) - 1) begin
                    m_disp = '0;
                    foreach (m_capq[i]) m_disp = {m_disp[DB-2:0], m_capq[i]};
                end
            end
            nxt = (m_pos + 1) % FB;
            if (m_locked && nxt >= int'(drv_lo) && nxt < int'(drv_hi)) begin
                if (nxt == int'(drv_lo)) begin
                    m_txq.delete();
                    for (int b = 7; b >= 0; b--) m_txq.push_back(drv_byte[b]);
                end
                m_oe = 1;
                m_tx = (m_txq.size() > 0) ? m_txq.pop_front() : 1'b0;
            end else begin
                m_oe = 0; m_tx = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (line_oe) any_oe = 1'b1;
        if (!rst) begin
            chk(disp_out == m_disp, "R5", "disp vs model", 64'(disp_out), 64'(m_disp));
            chk(line_oe == m_oe, "R8", "oe vs model", 64'(line_oe), 64'(m_oe));
            chk(line_out == m_tx, "R7", "line_out vs model", 64'(line_out), 64'(m_tx));
        end
    endtask

    task automatic send(input bit fs, input bit b, input int p);
        if (p == chg_at) drv_byte = chg_val;
        step();
        obs_oe[p] = line_oe;
        obs_tx[p] = line_out;
        bit_tick = 1'b1; fsync_n = fs; line_in = b;
        step();
        bit_tick = 1'b0; fsync_n = 1'b1;
    endtask

    function automatic bit pat(int p, int seed);
        return (((p * 7) + (seed * 13) + (p >> 2) + (p * seed)) % 3) == 0;
    endfunction

    task automatic run(input int start, input int n, input int s_in, input int s_out, input bit sync_first);
        for (int k = 0; k < n; k++) begin
            int p;
            p = (start + k) % FB;
            send((k == 0 && sync_first) ? 1'b0 : 1'b1,
                 (p >= int'(cap_lo) && p < int'(cap_hi)) ? pat(p, s_in) : pat(p, s_out), p);
        end
    endtask

    function automatic logic [DB-1:0] exp_disp(int lo, int hi, int seed);
        logic [DB-1:0] d = '0;
        for (int p = lo; p < hi; p++) d = {d[DB-2:0], pat(p, seed)};
        return d;
    endfunction

    task automatic chk_drive(input string req, input int lo, input int nb, input logic [7:0] val);
        for (int i = 0; i < nb; i++) begin
            chk(obs_tx[lo + i] == val[7 - i], req, "driven bit", 64'(obs_tx[lo + i]), 64'(val[7 - i]));
            chk(obs_oe[lo + i] == 1'b1, "R8", "oe inside window", 64'(obs_oe[lo + i]), 64'd1);
        end
        chk(obs_oe[lo - 1] == 1'b0, "R8", "oe before window", 64'(obs_oe[lo - 1]), 64'd0);
        chk(obs_oe[lo + nb] == 1'b0, "R8", "oe after window", 64'(obs_oe[lo + nb]), 64'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(disp_out == '0, "R1", "reset disp", 64'(disp_out), 64'd0);
        chk(line_oe == 1'b0 && line_out == 1'b0, "R1", "reset line", {62'd0, line_oe, line_out}, 64'd0);
        rst = 1'b0;
        step();
        chk(disp_out == '0 && !line_oe && !line_out, "R1", "after release", 64'(disp_out), 64'd0);

        // R3: activity before any frame marker
        run(0, 150, 1, 1, 1'b0);
        chk(disp_out == '0, "R3", "no capture unlocked", 64'(disp_out), 64'd0);
        chk(any_oe == 1'b0, "R3", "no drive unlocked", 64'(any_oe), 64'd0);

        // frame A: full frame, byte changed mid-window (R10)
        drv_byte = 8'hA5; chg_at = 99; chg_val = 8'h3C;
        run(0, FB, 2, 9, 1'b1);
        chg_at = -1;
        chk(disp_out == exp_disp(32, 72, 2), "R4", "frame A display", 64'(disp_out), 64'(exp_disp(32, 72, 2)));
        chk_drive("R10", 96, 8, 8'hA5);

        // frame B: window bits equal, outside bits differ (R6), then wrap with no marker (R2)
        drv_byte = 8'h5A;
        run(0, FB, 2, 7, 1'b1);
        chk(disp_out == exp_disp(32, 72, 2), "R6", "outside bits ignored", 64'(disp_out), 64'(exp_disp(32, 72, 2)));
        chk_drive("R7", 96, 8, 8'h5A);
        run(0, 60, 4, 4, 1'b0);
        chk(disp_out == exp_disp(32, 72, 2), "R5", "mid-window hold", 64'(disp_out), 64'(exp_disp(32, 72, 2)));
        run(60, 20, 4, 4, 1'b0);
        chk(disp_out == exp_disp(32, 72, 4), "R2", "capture after wrap", 64'(disp_out), 64'(exp_disp(32, 72, 4)));

        // R9: marker eighteen bits into the capture window
        run(0, 50, 5, 5, 1'b1);
        chk(disp_out == exp_disp(32, 72, 4), "R5", "cut frame no update", 64'(disp_out), 64'(exp_disp(32, 72, 4)));
        run(0, 72, 6, 6, 1'b1);
        chk(disp_out == exp_disp(32, 72, 6), "R9", "restart after marker", 64'(disp_out), 64'(exp_disp(32, 72, 6)));

        // narrow layout: 8-bit capture, 4-bit drive
        cap_lo = 10'd8; cap_hi = 10'd16; drv_lo = 10'd20; drv_hi = 10'd24; drv_byte = 8'h96;
        run(0, 30, 8, 3, 1'b1);
        chk(disp_out == exp_disp(8, 16, 8), "R4", "narrow zero fill", 64'(disp_out), 64'(exp_disp(8, 16, 8)));
        chk(disp_out[DB-1:8] == '0, "R4", "upper bytes zero", 64'(disp_out[DB-1:8]), 64'd0);
        chk_drive("R7", 20, 4, 8'h96);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule